// File: doc/BRIEF.md
# Pipeline Exception Entry Controller

This block is the exception-capture logic for a three-stage fetch/decode/execute core with 32-bit fixed-length instructions. It owns the fetch program counter. It tracks, through a small state machine, which pipeline stages hold a live instruction. The instruction in decode lies at the fetch address minus 4, and the instruction in execute lies at the fetch address minus 8.

Several sources can raise an exception:
- software-interrupt and undefined-instruction flags reported by the executing instruction;
- active-low normal and fast interrupt pins;
- an abort tag that travels with each fetched instruction;
- a data-abort response for the load/store that retired in the previous cycle.

When one or more sources are live, a fixed priority picks the winner. The block then outputs:
- a link value, which is always the current fetch address minus 4;
- the vector address;
- a 5-bit mode code;
- a flush that squashes decode and fetch.

Whether the fetch address has already moved past the faulting instruction depends on the class of exception. For this reason each class needs its own return adjustment: none, minus 4 or minus 8.

A return request from the executing instruction reloads the fetch address and restores the mode and the two interrupt-disable bits. This lets the handler's return path be checked end to end.

The state machine has four states:
- BOOT: held in reset, then takes the reset entry.
- FILL1: fetch live only.
- FILL2: fetch and decode live.
- RUN: all three stages live.

The transitions are as follows:
- boot-entry: BOOT to FILL1, in the first cycle after reset is released.
- fill-step: FILL1 to FILL2.
- fill-done: FILL2 to RUN.
- redirect: any state to FILL1, on an exception or a return.
- run-hold: RUN to RUN.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` is 0, `irq_dis` and `fiq_dis` are 1, `cur_mode` is 5'b10011 and `exec_valid` is 0. In the first cycle after release, `exc_take` is 1 with `exc_vector` 0x00 and `exc_mode` 5'b10011.
- R2: Outside a redirect, `fetch_pc` advances by 4 every cycle. After a redirect to address A, `exec_valid` rises two cycles later with `exec_pc` equal to A and `exec_pc` always equal to `fetch_pc` minus 8.
- R3: If `exec_undef` or `exec_swi` is high while `exec_valid` is high, the exception is taken without advancing the PC. `exc_link` equals `exec_pc`+4, which is also the return target. Undefined uses vector 0x04 and mode 5'b11011. Software interrupt uses vector 0x08 and mode 5'b10011.
- R4: An interrupt is taken when `exec_valid` is high, its pin is low and its disable bit is clear. `exc_link` equals `exec_pc`+4, and a return to `exc_link`-4 resumes at the interrupted instruction. The normal interrupt uses vector 0x18 and mode 5'b10010. The fast interrupt uses vector 0x1C and mode 5'b10001.
- R5: `fetch_abort` tags the instruction fetched in that cycle. The exception is raised only when that instruction is in execute, with vector 0x0C and mode 5'b10111. A return to `exc_link`-4 re-executes the aborted instruction.
- R6: `dabort` refers to the instruction that retired in the previous cycle. It gives `exc_link` equal to that instruction's address+8, vector 0x10 and mode 5'b10111, and a return to `exc_link`-8 retries it. It is ignored when no non-return instruction retired in the previous cycle.
- R7: Among simultaneous sources, the winner is chosen in this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt.
- R8: Every exception asserts `flush`. In the next cycle `exec_valid` is 0, and the abort tag of a squashed instruction never raises an exception.
- R9: Every exception entry sets `irq_dis`. `fiq_dis` is set on fast-interrupt and reset entry and keeps its value on every other entry.
- R10: An interrupt whose disable bit is set is ignored, and the executing instruction retires.
- R11: With `exec_valid` high and no exception, `ret_valid` redirects fetch to `ret_addr` and loads `cur_mode`, `irq_dis` and `fiq_dis` from `ret_mode`, `ret_irq_dis` and `ret_fiq_dis`. If an exception is taken in the same cycle, the return is ignored.
- R12: `retire` is high exactly when `exec_valid` is high and no exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_abort | input | 1 | Abort tag for the instruction fetched this cycle |
| exec_swi | input | 1 | Executing instruction is a software interrupt |
| exec_undef | input | 1 | Executing instruction is undefined |
| dabort | input | 1 | Data-abort response for the previously retired instruction |
| irq_n | input | 1 | Normal interrupt pin, active low |
| fiq_n | input | 1 | Fast interrupt pin, active low |
| ret_valid | input | 1 | Executing instruction is an exception return |
| ret_addr | input | AW | Return target address |
| ret_mode | input | 5 | Mode restored on return |
| ret_irq_dis | input | 1 | Normal-interrupt disable restored on return |
| ret_fiq_dis | input | 1 | Fast-interrupt disable restored on return |
| fetch_pc | output | AW | Current fetch address |
| exec_pc | output | AW | Address of the executing instruction |
| exec_valid | output | 1 | Execute stage holds a live instruction |
| retire | output | 1 | Executing instruction completes this cycle |
| exc_take | output | 1 | Exception entry this cycle |
| exc_vector | output | AW | Vector address of the entry |
| exc_link | output | AW | Saved link value (fetch address minus 4) |
| exc_mode | output | 5 | Mode code of the entry |
| flush | output | 1 | Squash decode and fetch |
| cur_mode | output | 5 | Current mode code |
| irq_dis | output | 1 | Normal-interrupt disable bit |
| fiq_dis | output | 1 | Fast-interrupt disable bit |

## Verification
Some properties are checked by the assertions on every cycle:
- the priority grant is one-hot;
- the refill order is FILL1, FILL2, RUN;
- `exec_valid` drops after every flush;
- abort tags are cleared on a flush;
- the fetch address steps by exactly 4 or jumps to the vector or the return target;
- `irq_dis` is set on every entry and `fiq_dis` keeps its value on other entries;
- a data abort is accepted only after a retirement.

Other behaviour can only be shown by the bench's scenarios:
- that each class's link and return adjustment resumes at the right instruction;
- that a prefetch abort waits for the tagged instruction to reach execute;
- that masked interrupts and squashed tags have no effect.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Index order is the priority order, 0 highest
    typedef enum logic [2:0] {
        C_RESET = 3'd0,
        C_DABT  = 3'd1,
        C_FIQ   = 3'd2,
        C_IRQ   = 3'd3,
        C_PABT  = 3'd4,
        C_UND   = 3'd5,
        C_SWI   = 3'd6,
        C_NONE  = 3'd7
    } cause_e;

    localparam int NUM_CAUSE = 7;

    typedef enum logic [1:0] {
        S_BOOT  = 2'd0,
        S_FILL1 = 2'd1,
        S_FILL2 = 2'd2,
        S_RUN   = 2'd3
    } pipe_state_e;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;

    function automatic logic [7:0] vec_offset(input cause_e c);
        case (c)
            C_RESET: return 8'h00;
            C_UND:   return 8'h04;
            C_SWI:   return 8'h08;
            C_PABT:  return 8'h0C;
            C_DABT:  return 8'h10;
            C_IRQ:   return 8'h18;
            C_FIQ:   return 8'h1C;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [4:0] mode_for(input cause_e c);
        case (c)
            C_RESET: return M_SVC;
            C_SWI:   return M_SVC;
            C_UND:   return M_UND;
            C_PABT:  return M_ABT;
            C_DABT:  return M_ABT;
            C_IRQ:   return M_IRQ;
            C_FIQ:   return M_FIQ;
            default: return M_USR;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int N = NUM_CAUSE
) (
    input  logic [N-1:0] req_i,
    output cause_e       cause_o,
    output logic         any_o
);

    logic [N:0]   seen;
    logic [N-1:0] grant;

    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pri
            assign grant[i]  = req_i[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req_i[i];
        end
    endgenerate

    assign any_o = seen[N];

    always_comb begin
        cause_o = C_NONE;
        for (int j = N - 1; j >= 0; j--) begin
            if (grant[j]) cause_o = cause_e'(3'(j));
        end
    end

    // R7: at most one winner, and a winner whenever anything is pending
    always_comb begin
        p_grant_onehot_r7: assert ($onehot0(grant));
        p_winner_present_r7: assert ((cause_o != C_NONE) == (req_i != '0));
    end

endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    output logic boot_o,
    output logic dec_valid_o,
    output logic exec_valid_o
);

    pipe_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_BOOT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_BOOT:  st_d = flush_i ? S_FILL1 : S_BOOT;
            S_FILL1: st_d = flush_i ? S_FILL1 : S_FILL2;
            S_FILL2: st_d = flush_i ? S_FILL1 : S_RUN;
            S_RUN:   st_d = flush_i ? S_FILL1 : S_RUN;
        endcase
    end

    always_comb begin
        boot_o       = (st_q == S_BOOT);
        dec_valid_o  = (st_q == S_FILL2) || (st_q == S_RUN);
        exec_valid_o = (st_q == S_RUN);
    end

    p_flush_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q == S_FILL1) && !exec_valid_o);

    p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_FILL1) && !flush_i |=> (st_q == S_FILL2));

    p_fill_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_FILL2) && !flush_i |=> exec_valid_o);

endmodule

// File: rtl/exc_pipe_regs.sv
module exc_pipe_regs #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_i,
    input  logic          take_i,
    input  logic [AW-1:0] vector_i,
    input  logic          ret_load_i,
    input  logic [AW-1:0] ret_addr_i,
    input  logic          fetch_abort_i,
    input  logic          retire_plain_i,
    output logic [AW-1:0] pc_o,
    output logic          exe_abort_o,
    output logic          retired_o
);

    logic [AW-1:0] pc_q;
    logic          dec_abt_q;
    logic          exe_abt_q;
    logic          retired_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            dec_abt_q <= 1'b0;
            exe_abt_q <= 1'b0;
            retired_q <= 1'b0;
        end else begin
            retired_q <= retire_plain_i;
            if (take_i) begin
                pc_q      <= vector_i;
                dec_abt_q <= 1'b0;
                exe_abt_q <= 1'b0;
            end else if (ret_load_i) begin
                pc_q      <= ret_addr_i;
                dec_abt_q <= 1'b0;
                exe_abt_q <= 1'b0;
            end else if (!boot_i) begin
                pc_q      <= pc_q + AW'(STEP);
                exe_abt_q <= dec_abt_q;
                dec_abt_q <= fetch_abort_i;
            end
        end
    end

    assign pc_o        = pc_q;
    assign exe_abort_o = exe_abt_q;
    assign retired_o   = retired_q;

    p_squash_tags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !exe_abort_o);

    p_redirect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ret_load_i && !take_i |=> pc_o == $past(ret_addr_i));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i && !ret_load_i && !boot_i |=> pc_o == $past(pc_o) + AW'(STEP));

endmodule

// File: rtl/exc_status.sv
module exc_status
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take_i,
    input  cause_e     cause_i,
    input  logic       ret_load_i,
    input  logic [4:0] ret_mode_i,
    input  logic       ret_irq_dis_i,
    input  logic       ret_fiq_dis_i,
    output logic [4:0] mode_o,
    output logic       irq_dis_o,
    output logic       fiq_dis_o
);

    logic [4:0] mode_q;
    logic       irq_dis_q;
    logic       fiq_dis_q;
    logic       masks_fiq;

    assign masks_fiq = (cause_i == C_FIQ) || (cause_i == C_RESET);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= M_SVC;
            irq_dis_q <= 1'b1;
            fiq_dis_q <= 1'b1;
        end else if (take_i) begin
            mode_q    <= mode_for(cause_i);
            irq_dis_q <= 1'b1;
            if (masks_fiq) fiq_dis_q <= 1'b1;
        end else if (ret_load_i) begin
            mode_q    <= ret_mode_i;
            irq_dis_q <= ret_irq_dis_i;
            fiq_dis_q <= ret_fiq_dis_i;
        end
    end

    assign mode_o    = mode_q;
    assign irq_dis_o = irq_dis_q;
    assign fiq_dis_o = fiq_dis_q;

    p_entry_masks_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> irq_dis_o);

    p_fiq_mask_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !masks_fiq |=> fiq_dis_o == $past(fiq_dis_o));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_abort,
    input  logic          exec_swi,
    input  logic          exec_undef,
    input  logic          dabort,
    input  logic          irq_n,
    input  logic          fiq_n,
    input  logic          ret_valid,
    input  logic [AW-1:0] ret_addr,
    input  logic [4:0]    ret_mode,
    input  logic          ret_irq_dis,
    input  logic          ret_fiq_dis,
    output logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] exec_pc,
    output logic          exec_valid,
    output logic          retire,
    output logic          exc_take,
    output logic [AW-1:0] exc_vector,
    output logic [AW-1:0] exc_link,
    output logic [4:0]    exc_mode,
    output logic          flush,
    output logic [4:0]    cur_mode,
    output logic          irq_dis,
    output logic          fiq_dis
);

    localparam int STEP      = 4;
    localparam int LINK_BACK = STEP;
    localparam int EXEC_BACK = 2 * STEP;

    logic                 boot;
    logic                 dec_valid;
    logic                 exe_abort;
    logic                 retired_prev;
    logic                 ret_load;
    logic [NUM_CAUSE-1:0] req;
    cause_e               cause;
    logic                 take;
    logic [AW-1:0]        vector;

    exc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .boot_o       (boot),
        .dec_valid_o  (dec_valid),
        .exec_valid_o (exec_valid)
    );

    always_comb begin
        req          = '0;
        req[C_RESET] = boot;
        req[C_DABT]  = dabort && retired_prev;
        req[C_FIQ]   = exec_valid && !fiq_n && !fiq_dis;
        req[C_IRQ]   = exec_valid && !irq_n && !irq_dis;
        req[C_PABT]  = exec_valid && exe_abort;
        req[C_UND]   = exec_valid && exec_undef;
        req[C_SWI]   = exec_valid && exec_swi;
    end

    exc_arbiter #(.N(NUM_CAUSE)) u_arb (
        .req_i   (req),
        .cause_o (cause),
        .any_o   (take)
    );

    assign vector   = VEC_BASE + AW'(vec_offset(cause));
    assign ret_load = exec_valid && ret_valid && !take;
    assign retire   = exec_valid && !take;
    assign flush    = take || ret_load;

    exc_pipe_regs #(.AW(AW), .STEP(STEP)) u_pipe (
        .clk            (clk),
        .rst_n          (rst_n),
        .boot_i         (boot),
        .take_i         (take),
        .vector_i       (vector),
        .ret_load_i     (ret_load),
        .ret_addr_i     (ret_addr),
        .fetch_abort_i  (fetch_abort),
        .retire_plain_i (retire && !ret_valid),
        .pc_o           (fetch_pc),
        .exe_abort_o    (exe_abort),
        .retired_o      (retired_prev)
    );

    exc_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_i        (take),
        .cause_i       (cause),
        .ret_load_i    (ret_load),
        .ret_mode_i    (ret_mode),
        .ret_irq_dis_i (ret_irq_dis),
        .ret_fiq_dis_i (ret_fiq_dis),
        .mode_o        (cur_mode),
        .irq_dis_o     (irq_dis),
        .fiq_dis_o     (fiq_dis)
    );

    assign exec_pc    = fetch_pc - AW'(EXEC_BACK);
    assign exc_take   = take;
    assign exc_vector = take ? vector : '0;
    assign exc_link   = (take && !boot) ? (fetch_pc - AW'(LINK_BACK)) : '0;
    assign exc_mode   = take ? mode_for(cause) : M_USR;

    p_dabt_after_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take && (cause == C_DABT) |-> $past(retire) && !$past(ret_valid));

    p_decode_before_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> dec_valid);

    p_no_retire_on_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !exec_valid);

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, fetch_abort, exec_swi, exec_undef, dabort, irq_n, fiq_n;
    logic        ret_valid, ret_irq_dis, ret_fiq_dis;
    logic [31:0] ret_addr;
    logic [4:0]  ret_mode;
    logic [31:0] fetch_pc, exec_pc, exc_vector, exc_link;
    logic        exec_valid, retire, exc_take, flush, irq_dis, fiq_dis;
    logic [4:0]  exc_mode, cur_mode;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_abort(fetch_abort), .exec_swi(exec_swi),
        .exec_undef(exec_undef), .dabort(dabort), .irq_n(irq_n), .fiq_n(fiq_n),
        .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_mode(ret_mode),
        .ret_irq_dis(ret_irq_dis), .ret_fiq_dis(ret_fiq_dis),
        .fetch_pc(fetch_pc), .exec_pc(exec_pc), .exec_valid(exec_valid),
        .retire(retire), .exc_take(exc_take), .exc_vector(exc_vector),
        .exc_link(exc_link), .exc_mode(exc_mode), .flush(flush),
        .cur_mode(cur_mode), .irq_dis(irq_dis), .fiq_dis(fiq_dis)
    );

    localparam logic [4:0] MD_USR = 5'b10000, MD_FIQ = 5'b10001, MD_IRQ = 5'b10010;
    localparam logic [4:0] MD_SVC = 5'b10011, MD_ABT = 5'b10111, MD_UND = 5'b11011;
    localparam logic [2:0] K_SWI = 3'd0, K_UND = 3'd1, K_IRQ = 3'd2;
    localparam logic [2:0] K_FIQ = 3'd3, K_PABT = 3'd4, K_DABT = 3'd5;

    typedef struct packed {
        logic [2:0]  kind;
        logic [31:0] start;
        logic [3:0]  k;
        logic [31:0] link;
        logic [31:0] resume;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{K_SWI,  32'h100, 4'd2, 32'h10C, 32'h10C},
        '{K_UND,  32'h200, 4'd0, 32'h204, 32'h204},
        '{K_IRQ,  32'h300, 4'd3, 32'h310, 32'h30C},
        '{K_FIQ,  32'h400, 4'd1, 32'h408, 32'h404},
        '{K_PABT, 32'h500, 4'd2, 32'h50C, 32'h508},
        '{K_DABT, 32'h600, 4'd2, 32'h60C, 32'h604},
        '{K_PABT, 32'h700, 4'd0, 32'h704, 32'h700},
        '{K_DABT, 32'h800, 4'd1, 32'h808, 32'h800}
    };

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    bit          pabt_armed = 0;
    logic [31:0] pabt_addr  = '0;

    function automatic logic [31:0] exp_vec(input logic [2:0] kd);
        case (kd)
            K_SWI:   return 32'h08;
            K_UND:   return 32'h04;
            K_IRQ:   return 32'h18;
            K_FIQ:   return 32'h1C;
            K_PABT:  return 32'h0C;
            default: return 32'h10;
        endcase
    endfunction

    function automatic logic [4:0] exp_mode(input logic [2:0] kd);
        case (kd)
            K_SWI:   return MD_SVC;
            K_UND:   return MD_UND;
            K_IRQ:   return MD_IRQ;
            K_FIQ:   return MD_FIQ;
            default: return MD_ABT;
        endcase
    endfunction

    function automatic logic [31:0] exp_adj(input logic [2:0] kd);
        case (kd)
            K_SWI, K_UND: return 32'd0;
            K_DABT:       return 32'd8;
            default:      return 32'd4;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] kd);
        case (kd)
            K_SWI, K_UND: return "R3";
            K_IRQ, K_FIQ: return "R4";
            K_PABT:       return "R5";
            default:      return "R6";
        endcase
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic idle();
        exec_swi = 0; exec_undef = 0; dabort = 0; irq_n = 1; fiq_n = 1;
        ret_valid = 0; ret_addr = '0; ret_mode = MD_USR; ret_irq_dis = 0; ret_fiq_dis = 0;
    endtask

    // Advance one edge; land 1 ns after it with the abort tag driven for the new fetch
    task automatic cyc();
        @(posedge clk);
        #1;
        fetch_abort = pabt_armed && (fetch_pc == pabt_addr);
    endtask

    task automatic go_run();
        while (!exec_valid) cyc();
    endtask

    task automatic do_return(input logic [31:0] a, input logic id, input logic fd);
        go_run();
        ret_valid = 1; ret_addr = a; ret_mode = MD_USR; ret_irq_dis = id; ret_fiq_dis = fd;
        cyc();
        ret_valid = 0;
    endtask

    initial begin
        rst_n = 0; fetch_abort = 0;
        idle();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 pc", fetch_pc, 32'h0);
        chk("R1 irq_dis", {31'b0, irq_dis}, 32'd1);
        chk("R1 fiq_dis", {31'b0, fiq_dis}, 32'd1);
        chk("R1 mode", {27'b0, cur_mode}, {27'b0, MD_SVC});
        chk("R1 exec_valid", {31'b0, exec_valid}, 32'd0);
        rst_n = 1;
        #3;
        chk("R1 take", {31'b0, exc_take}, 32'd1);
        chk("R1 vector", exc_vector, 32'h0);
        chk("R1 entry mode", {27'b0, exc_mode}, {27'b0, MD_SVC});
        cyc();
        chk("R2 fill1 pc", fetch_pc, 32'h0);
        chk("R2 fill1 exec", {31'b0, exec_valid}, 32'd0);
        cyc();
        chk("R2 fill2 pc", fetch_pc, 32'h4);
        cyc();
        #3;
        chk("R2 run exec_valid", {31'b0, exec_valid}, 32'd1);
        chk("R2 run exec_pc", exec_pc, 32'h0);
        chk("R12 retire idle", {31'b0, retire}, 32'd1);

        // Vector table: entry, link, handler return, resume address
        for (int v = 0; v < NV; v++) begin
            vec_t c;
            logic [31:0] f;
            c = TBL[v];
            f = c.start + 32'(c.k) * 32'd4;
            pabt_armed = (c.kind == K_PABT);
            pabt_addr  = f;
            do_return(c.start, 1'b0, 1'b0);
            chk("R11 mode restored", {27'b0, cur_mode}, {27'b0, MD_USR});
            cyc(); cyc();
            chk("R2 exec_pc after return", exec_pc, c.start);
            for (int s = 0; s < int'(c.k); s++) cyc();
            chk("R2 exec at fault", exec_pc, f);
            case (c.kind)
                K_SWI:   exec_swi = 1;
                K_UND:   exec_undef = 1;
                K_IRQ:   irq_n = 0;
                K_FIQ:   fiq_n = 0;
                K_DABT:  dabort = 1;
                default: ;
            endcase
            #3;
            chk(req_of(c.kind), {31'b0, exc_take}, 32'd1);
            chk(req_of(c.kind), exc_vector, exp_vec(c.kind));
            chk(req_of(c.kind), {27'b0, exc_mode}, {27'b0, exp_mode(c.kind)});
            chk(req_of(c.kind), exc_link, c.link);
            chk("R8 flush", {31'b0, flush}, 32'd1);
            cyc();
            idle();
            pabt_armed = 0;
            chk("R8 exec squashed", {31'b0, exec_valid}, 32'd0);
            chk("R9 irq_dis", {31'b0, irq_dis}, 32'd1);
            chk("R9 fiq_dis", {31'b0, fiq_dis}, (c.kind == K_FIQ) ? 32'd1 : 32'd0);
            chk("R2 vector fetch", fetch_pc, exp_vec(c.kind));
            do_return(c.link - exp_adj(c.kind), 1'b0, 1'b0);
            cyc(); cyc();
            chk(req_of(c.kind), exec_pc, c.resume);
        end

        // R7 data abort beats everything, R11 return ignored with it
        do_return(32'h900, 1'b0, 1'b0);
        cyc(); cyc(); cyc();
        dabort = 1; fiq_n = 0; irq_n = 0; exec_swi = 1; ret_valid = 1; ret_addr = 32'hABC;
        #3;
        chk("R7 dabt wins", exc_vector, 32'h10);
        chk("R12 no retire on take", {31'b0, retire}, 32'd0);
        cyc();
        idle();
        chk("R11 return ignored", fetch_pc, 32'h10);
        chk("R9 dabt keeps fiq_dis", {31'b0, fiq_dis}, 32'd0);

        // R7 fast interrupt over normal, prefetch abort and undefined
        pabt_armed = 1; pabt_addr = 32'hA00;
        do_return(32'hA00, 1'b0, 1'b0);
        cyc(); cyc();
        fiq_n = 0; irq_n = 0; exec_undef = 1;
        #3;
        chk("R7 fiq wins", exc_vector, 32'h1C);
        cyc();
        idle(); pabt_armed = 0;
        chk("R9 fiq sets fiq_dis", {31'b0, fiq_dis}, 32'd1);

        // R7 normal interrupt over prefetch abort
        pabt_armed = 1; pabt_addr = 32'hB00;
        do_return(32'hB00, 1'b0, 1'b0);
        cyc(); cyc();
        irq_n = 0;
        #3;
        chk("R7 irq over pabt", exc_vector, 32'h18);
        cyc();
        idle(); pabt_armed = 0;

        // R7 prefetch abort over undefined
        pabt_armed = 1; pabt_addr = 32'hC00;
        do_return(32'hC00, 1'b0, 1'b0);
        cyc(); cyc();
        exec_undef = 1;
        #3;
        chk("R7 pabt over undef", exc_vector, 32'h0C);
        cyc();
        idle(); pabt_armed = 0;

        // R7 undefined over software interrupt
        do_return(32'hC80, 1'b0, 1'b0);
        cyc(); cyc();
        exec_undef = 1; exec_swi = 1;
        #3;
        chk("R7 undef over swi", exc_vector, 32'h04);
        cyc();
        idle();

        // R10 masked interrupts ignored
        do_return(32'hD00, 1'b1, 1'b1);
        cyc(); cyc();
        irq_n = 0; fiq_n = 0;
        #3;
        chk("R10 masked no take", {31'b0, exc_take}, 32'd0);
        chk("R10 retire", {31'b0, retire}, 32'd1);
        cyc();
        idle();
        chk("R10 progress", exec_pc, 32'hD04);

        // R8 squashed abort tag never fires
        pabt_armed = 1; pabt_addr = 32'hE08;
        do_return(32'hE00, 1'b0, 1'b0);
        cyc(); cyc();
        exec_swi = 1;
        #3;
        chk("R3 swi taken", exc_link, 32'hE04);
        cyc();
        idle(); pabt_armed = 0;
        do_return(32'hE04, 1'b0, 1'b0);
        cyc(); cyc();
        for (int s = 0; s < 3; s++) begin
            #3;
            chk("R8 squashed tag silent", {31'b0, exc_take}, 32'd0);
            cyc();
        end

        // R6 data abort ignored without a prior retirement
        do_return(32'hF00, 1'b0, 1'b0);
        cyc(); cyc();
        dabort = 1;
        #3;
        chk("R6 dabt ignored", {31'b0, exc_take}, 32'd0);
        cyc();
        idle();
        chk("R6 progress", exec_pc, 32'hF04);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule